// File: doc/BRIEF.md
# Oversampling Tick Generator

This block makes the sixteen-times oversampling strobe that a serial receiver and transmitter share. Software programs a 32-bit rate word that holds half of the clock divisor minus one. A small down-scaled counter runs through that half period, a phase bit flips at the end of each half, and a single-cycle tick comes out each time the phase goes from low to high. The tick period is therefore always an even number of clock cycles: two times the word plus one.

Software forms the word from the input clock and the wanted line rate. The divisor D is the clock divided by sixteen times the line rate. The word is D/2 rounded down when D is odd, and D/2 minus one when D is even. The generator runs only while its enable input is high. The usual sequence is to drop the enable, write a new word, and raise the enable again. A write strobe loads a new word and restarts the count on that same edge, so no shortened or stretched period is ever seen.

Top module: `baud_tick_gen`

## Requirements
- R1: Reset is synchronous and active low. While it is held, `tick` is 0. Reset also clears the stored rate word to 0 and restarts the phase.
- R2: `tick` is a pulse one clock wide. It is never high in two cycles in a row.
- R3: With `gen_en` held high, no write, and a stored word W, ticks come exactly 2*(W+1) cycles apart.
- R4: A stored word of 0 gives a tick every second cycle.
- R5: When `gen_en` is low at a clock edge, `tick` is 0 after that edge, and the count and phase restart. If `gen_en` is first sampled high at edge E, the first tick is high in the cycle after edge E+2W+1. That is a full period of 2*(W+1) cycles, never a partial one.
- R6: A write (`word_wr` high at an edge) while enabled loads `baud_word` and restarts the count on that edge. `tick` is 0 after the write edge. The following ticks are high after the write edge plus n*2*(W'+1) cycles, where W' is the new word.
- R7: A write while `gen_en` is low stores the word and gives no tick. The next enable then uses the new word.
- R8: The counter covers the full word width. Words above 8 bits, for example 300 with a period of 602, give the exact period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gen_en | input | 1 | Generator enable; low clears count and phase |
| word_wr | input | 1 | Write strobe that loads `baud_word` |
| baud_word | input | WORD_W | Rate word: half divisor minus one |
| tick | output | 1 | Single-cycle 16x oversampling strobe |

## Verification
The bench goes after the word value of 0. A design with an off-by-one in the compare would emit a tick every cycle there, or every fourth cycle. It drops the enable in the middle of a period and raises it again. A design that kept the old count or phase would give a shortened first period after the restart. It writes a new word in the middle of a period while enabled. A design that let the old count finish would emit a tick at the old spacing, or give a partial first period. It also uses a word wider than 8 bits, which catches a counter that is too narrow and wraps too early. Finally it applies reset during a run, which exposes a stored word that survives reset.

// File: rtl/baudgen_pkg.sv
// Package: baudgen_pkg
// Shared width and the command type used between the control decode and
// the counting stages of the oversampling tick generator.
package baudgen_pkg;

    // Width of the programmed rate word.
    localparam int unsigned WORD_W_DEF = 32;

    // Action applied to the counting stages on an edge.
    typedef enum logic [1:0] {
        GEN_CLEAR = 2'd0,   // generator off: restart count and phase
        GEN_LOAD  = 2'd1,   // new word written: restart count and phase
        GEN_RUN   = 2'd2    // count the half period
    } gen_cmd_e;

endpackage

// File: rtl/bg_ctrl.sv
// Module: bg_ctrl
// Holds the rate word and decodes enable and write strobe into one command
// per cycle. A write takes precedence over the enable level.
// Assumes: synchronous active-low reset; word resets to zero.
module bg_ctrl
    import baudgen_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gen_en,
    input  logic              word_wr,
    input  logic [WORD_W-1:0] baud_word,
    output logic [WORD_W-1:0] word_q,
    output gen_cmd_e          cmd
);

    // Capture the rate word on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (word_wr) begin
            word_q <= baud_word;
        end
    end

    // Decode the per-cycle command for the counting stages.
    always_comb begin
        if (word_wr) begin
            cmd = GEN_LOAD;
        end else if (gen_en) begin
            cmd = GEN_RUN;
        end else begin
            cmd = GEN_CLEAR;
        end
    end

endmodule

// File: rtl/bg_half_counter.sv
// Module: bg_half_counter
// Counts word+1 cycles per half period and flags the last cycle of each half.
// Assumes: word_q is stable while cmd is GEN_RUN (a change always comes with
// GEN_LOAD, which restarts the count).
module bg_half_counter
    import baudgen_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  gen_cmd_e          cmd,
    input  logic [WORD_W-1:0] word_q,
    output logic              half_done
);

    logic [WORD_W-1:0] cnt_q;

    // The half period ends when the count reaches the word while running.
    assign half_done = (cmd == GEN_RUN) && (cnt_q == word_q);

    // Advance the count, wrapping at the end of each half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cmd != GEN_RUN) begin
            cnt_q <= '0;
        end else if (half_done) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/bg_phase.sv
// Module: bg_phase
// Flips a phase bit at each half-period end and registers a tick on the
// low-to-high flip. The phase restarts high, so the first tick after a
// restart comes one full period later.
// Assumes: half_done is only high while cmd is GEN_RUN.
module bg_phase
    import baudgen_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  gen_cmd_e cmd,
    input  logic     half_done,
    output logic     tick
);

    logic phase_q;

    // Keep the phase and tick registers; restart on clear or load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b1;
            tick    <= 1'b0;
        end else if (cmd != GEN_RUN) begin
            phase_q <= 1'b1;
            tick    <= 1'b0;
        end else begin
            if (half_done) begin
                phase_q <= ~phase_q;
            end
            tick <= half_done && !phase_q;
        end
    end

endmodule

// File: rtl/baud_tick_gen.sv
// Module: baud_tick_gen
// Top of the oversampling tick generator. The period is 2*(word+1) cycles
// and a write reloads at once.
// Assumes: synchronous active-low reset; all inputs are in the clk domain.
module baud_tick_gen
    import baudgen_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gen_en,
    input  logic              word_wr,
    input  logic [WORD_W-1:0] baud_word,
    output logic              tick
);

    logic [WORD_W-1:0] word_q;
    gen_cmd_e          cmd;
    logic              half_done;

    bg_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .gen_en    (gen_en),
        .word_wr   (word_wr),
        .baud_word (baud_word),
        .word_q    (word_q),
        .cmd       (cmd)
    );

    bg_half_counter #(.WORD_W(WORD_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .word_q    (word_q),
        .half_done (half_done)
    );

    bg_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .half_done (half_done),
        .tick      (tick)
    );

endmodule

// File: rtl/baud_tick_gen_chk.sv
// Module: baud_tick_gen_chk
// Property checker bound to baud_tick_gen. It measures the spacing between
// ticks with its own counter and compares it with the stored word.
module baud_tick_gen_chk #(
    parameter int unsigned WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gen_en,
    input logic              word_wr,
    input logic              tick,
    input logic [WORD_W-1:0] word_q
);

    logic [WORD_W+1:0] gap_q;
    logic              armed_q;

    // Count the cycles since the last tick inside one uninterrupted run.
    always_ff @(posedge clk) begin
        if (!rst_n || !gen_en || word_wr) begin
            gap_q   <= '0;
            armed_q <= 1'b0;
        end else if (tick) begin
            gap_q   <= {{(WORD_W+1){1'b0}}, 1'b1};
            armed_q <= 1'b1;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R1: while reset is held, the next cycle shows no tick.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !tick);

    // R2: a tick lasts one cycle.
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R3: spacing between ticks equals 2*(word+1).
    a_r3_period: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && tick && gen_en && !word_wr)
            |-> (gap_q == (({2'b00, word_q} + 1'b1) << 1)));

    // R4: with word 0, a tick is followed two cycles later by another.
    a_r4_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tick && (word_q == '0) && gen_en && !word_wr) && gen_en && !word_wr)
            |=> tick);

    // R5: a low enable silences the next cycle.
    a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> !tick);

    // R6: a write edge is never followed directly by a tick.
    a_r6_reload_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        word_wr |=> !tick);

endmodule

bind baud_tick_gen baud_tick_gen_chk #(.WORD_W(WORD_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .gen_en  (gen_en),
    .word_wr (word_wr),
    .tick    (tick),
    .word_q  (word_q)
);

// File: tb/sim_baud_tick_gen.sv
// Scoreboard bench: driver tasks push the expected tick cycles, and a
// monitor pops and compares them as ticks appear.
module sim_baud_tick_gen;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gen_en = 1'b0;
    logic        word_wr = 1'b0;
    logic [31:0] baud_word = '0;
    logic        tick;

    int          cyc = 0;
    int          n_cmp = 0;
    int          n_bad = 0;
    int          n_seen = 0;
    int          exp_q[$];
    string       cur_req = "R3";
    bit          done = 1'b0;

    baud_tick_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .gen_en    (gen_en),
        .word_wr   (word_wr),
        .baud_word (baud_word),
        .tick      (tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Count rising edges; after edge k, cyc holds k.
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Monitor: pop and compare on each tick, and flag missing ticks.
    always @(negedge clk) begin
        if (rst_n) begin
            if (tick) begin
                n_seen++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, cur_req, "unexpected tick at cycle", cyc, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(cyc == e, cur_req, "tick cycle", cyc, e);
                end
            end else if (exp_q.size() > 0 && exp_q[0] < cyc) begin
                int e;
                e = exp_q.pop_front();
                chk(1'b0, cur_req, "missing tick", cyc, e);
            end
        end
    end

    task automatic push_ticks(input int base, input int period, input int n);
        for (int k = 1; k <= n; k++) exp_q.push_back(base + k * period);
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Write a word: strobe at the current negedge, write edge is cyc+1.
    task automatic write_word(input int w, output int t);
        @(negedge clk);
        t = cyc;
        baud_word = w;
        word_wr = 1'b1;
        @(negedge clk);
        word_wr = 1'b0;
    endtask

    // Enable with the stored word, expect n ticks, then disable and drain.
    task automatic run_enabled(input int w, input int n, input string req);
        int t;
        @(negedge clk);
        cur_req = req;
        t = cyc;
        gen_en = 1'b1;
        push_ticks(t, 2 * (w + 1), n);
        wait_to(t + n * 2 * (w + 1));
        gen_en = 1'b0;
        repeat (2 * (w + 1) + 4) @(negedge clk);
        chk(exp_q.size() == 0, req, "queue drained", exp_q.size(), 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        chk(1'b0, "R3", "watchdog expired at cycle", cyc, WATCHDOG);
        finish_run();
    end

    initial begin
        int t;
        int seen0;
        // R1: reset holds tick low.
        repeat (4) @(negedge clk);
        chk(tick == 1'b0, "R1", "tick during reset", tick, 0);
        rst_n = 1'b1;

        // R7: write while disabled gives no tick.
        cur_req = "R7";
        seen0 = n_seen;
        write_word(3, t);
        repeat (20) @(negedge clk);
        chk(n_seen == seen0, "R7", "ticks while disabled", n_seen - seen0, 0);

        // R3 and R7: the stored word 3 gives period 8.
        run_enabled(3, 5, "R3");
        write_word(5, t);
        run_enabled(5, 3, "R3");

        // R4: word 0 gives a tick every second cycle.
        write_word(0, t);
        run_enabled(0, 6, "R4");

        // R8: a word wider than 8 bits.
        write_word(300, t);
        run_enabled(300, 3, "R8");

        // R5: disable mid-period, then a full first period.
        cur_req = "R5";
        write_word(4, t);
        @(negedge clk);
        gen_en = 1'b1;
        repeat (6) @(negedge clk);
        gen_en = 1'b0;
        seen0 = n_seen;
        repeat (15) @(negedge clk);
        chk(n_seen == seen0, "R5", "ticks after disable", n_seen - seen0, 0);
        run_enabled(4, 3, "R5");

        // R6: a write mid-period while enabled reloads with no partial period.
        cur_req = "R6";
        write_word(6, t);
        @(negedge clk);
        t = cyc;
        gen_en = 1'b1;
        push_ticks(t, 14, 1);
        wait_to(t + 19);
        write_word(2, t);
        push_ticks(t + 1, 6, 4);
        wait_to(t + 1 + 24);
        gen_en = 1'b0;
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R6", "queue drained", exp_q.size(), 0);

        // R1: reset during a run clears tick and the stored word.
        cur_req = "R1";
        @(negedge clk);
        t = cyc;
        gen_en = 1'b1;
        push_ticks(t, 6, 2);
        wait_to(t + 13);
        rst_n = 1'b0;
        gen_en = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(tick == 1'b0, "R1", "tick held in reset", tick, 0);
        end
        rst_n = 1'b1;
        run_enabled(0, 4, "R1");

        chk(n_seen > 0, "R2", "ticks observed", n_seen, 1);
        finish_run();
    end

endmodule